// File: doc/BRIEF.md
# Horizontal Drive Startup Sequencer

This block decides when the horizontal output stage may be driven, and at what duty cycle, while the line timebase comes up. After a power-on reset it keeps the drive off until the control interface reports that every control register has been loaded. That event starts a line-oscillator frequency calibration. The drive is released only when calibration reports a correct frequency. It then soft-starts, with the duty cycle climbing from 0 % to 50 % over about one hundred line periods.

Once the drive runs at full duty, a loss of lock from the coincidence detector sends the block back into calibration. A control bit lets the drive run at full duty before calibration has finished. All pins are plain level or single-cycle control signals; no streaming data passes through the block. The oscillator, the frequency comparison and the pulse-width pin driver sit outside it.

Top module: `hdrv_startup_seq`

## Requirements
- R1: While `rst_n` is low, `hdrv_en` is 0, `cal_req` is 0 and `duty_pct` is 0.
- R2: A high `por_flag` drops `hdrv_en` to 0 in the same cycle, from any state. After `por_flag` falls, the block waits again for a register download, and `cal_req` stays 0 until `regs_written` is seen.
- R3: A one-cycle `regs_written` pulse while waiting raises `cal_req` on the next cycle. `cal_req` stays high until `cal_done`.
- R4: With `cal_gate` = 1, `hdrv_en` is 0 while waiting for registers and while calibrating.
- R5: `cal_done` during calibration (with `cal_gate` = 1) clears `cal_req` on the next cycle and starts the soft start: `hdrv_en` = 1 and `duty_pct` = 0.
- R6: During soft start, `duty_pct` rises by 1 on every second `line_pulse`. It reads k after 2k pulses and reaches 50 after 100 pulses.
- R7: After 50 is reached, the block enters full drive. `duty_pct` stays at 50 and `hdrv_en` at 1 as further line pulses arrive.
- R8: In full drive, `lock_ok` = 0 returns the block to calibration on the next cycle. `cal_req` becomes 1, and with `cal_gate` = 1, `hdrv_en` and `duty_pct` become 0.
- R9: During soft start, `lock_ok` = 0 has no effect: `cal_req` stays 0 and the ramp continues.
- R10: With `cal_gate` = 0, `hdrv_en` = 1 and `duty_pct` = 50 while waiting or calibrating. `cal_done` then moves straight to full drive at 50, with no ramp.
- R11: Line pulses outside soft start leave `duty_pct` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_flag | input | 1 | Power-on-reset detected |
| line_pulse | input | 1 | One-cycle pulse per line period |
| regs_written | input | 1 | One-cycle pulse: all control registers loaded |
| cal_done | input | 1 | Calibration found the correct frequency |
| lock_ok | input | 1 | Coincidence detector reports lock |
| cal_gate | input | 1 | 1: drive waits for calibration; 0: drive allowed early |
| cal_req | output | 1 | Request to run oscillator calibration |
| hdrv_en | output | 1 | Horizontal drive enable |
| duty_pct | output | DUTY_W (7) | Drive duty cycle in percent |

## Verification
The bench targets the ramp's end points. It checks the value after the first two pulses, the value one pulse before the top (49), and that the value holds at 50 afterwards. A prescaler that is off by one, or a missing clamp, would show up as 48, 51 or continued growth. It drops lock in the middle of the soft start, where a design that reacts would fall back into calibration and cut the drive. It also drops lock in full drive, where a design that ignores it would keep driving unlocked. It raises the power-on flag while driving and checks the enable in that same cycle. It covers the early-drive mode, where a design that still ramped would make the duty jump from 50 to 0 at calibration done.

// File: rtl/hds_pkg.sv
package hds_pkg;
  typedef enum logic [2:0] {
    HS_OFF  = 3'd0,
    HS_WAIT = 3'd1,
    HS_CAL  = 3'd2,
    HS_SOFT = 3'd3,
    HS_RUN  = 3'd4
  } hds_state_t;
endpackage

// File: rtl/hds_ramp.sv
module hds_ramp #(
  parameter int DUTY_MAX       = 50,
  parameter int LINES_PER_STEP = 2,
  parameter int DUTY_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              line_pulse,
  output logic [DUTY_W-1:0] duty,
  output logic              at_max
);
  localparam int PC_W = (LINES_PER_STEP > 1) ? $clog2(LINES_PER_STEP) : 1;
  localparam logic [PC_W-1:0]   PC_LAST = PC_W'(LINES_PER_STEP - 1);
  localparam logic [DUTY_W-1:0] MAX_V   = DUTY_W'(DUTY_MAX);

  logic [PC_W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      pcnt <= '0;
      duty <= '0;
    end else if (line_pulse) begin
      if (pcnt == PC_LAST) begin
        pcnt <= '0;
        if (duty < MAX_V) duty <= duty + 1'b1;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  assign at_max = (duty == MAX_V);

  // R6: the duty moves by at most one step per cycle while ramping
  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (duty == $past(duty) || duty == $past(duty) + 1'b1));

  // R7: the duty never passes its ceiling
  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= MAX_V);
endmodule

// File: rtl/hds_fsm.sv
module hds_fsm
  import hds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_flag,
  input  logic       regs_written,
  input  logic       cal_done,
  input  logic       lock_ok,
  input  logic       cal_gate,
  input  logic       at_max,
  output hds_state_t state
);
  hds_state_t nxt;

  always_comb begin
    nxt = state;
    if (por_flag) begin
      nxt = HS_OFF;
    end else begin
      unique case (state)
        HS_OFF:  nxt = HS_WAIT;
        HS_WAIT: if (regs_written) nxt = HS_CAL;
        HS_CAL:  if (cal_done) nxt = cal_gate ? HS_SOFT : HS_RUN;
        HS_SOFT: if (at_max) nxt = HS_RUN;
        HS_RUN:  if (!lock_ok) nxt = HS_CAL;
        default: nxt = HS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= HS_OFF;
    else        state <= nxt;
  end

  // R2: power-on reset forces the idle state
  p_por_forces_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    por_flag |=> (state == HS_OFF));

  // R3: a register download starts calibration
  p_download_starts_cal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_WAIT && regs_written && !por_flag) |=> (state == HS_CAL));

  // R8: lock loss in full drive recalibrates
  p_unlock_recal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_RUN && !lock_ok && !por_flag) |=> (state == HS_CAL));

  // R9: soft start never falls back into calibration
  p_soft_ignores_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_SOFT && !por_flag) |=> (state == HS_SOFT || state == HS_RUN));
endmodule

// File: rtl/hdrv_startup_seq.sv
module hdrv_startup_seq
  import hds_pkg::*;
#(
  parameter int DUTY_MAX       = 50,
  parameter int LINES_PER_STEP = 2,
  parameter int DUTY_W         = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_flag,
  input  logic              line_pulse,
  input  logic              regs_written,
  input  logic              cal_done,
  input  logic              lock_ok,
  input  logic              cal_gate,
  output logic              cal_req,
  output logic              hdrv_en,
  output logic [DUTY_W-1:0] duty_pct
);
  localparam logic [DUTY_W-1:0] MAX_V = DUTY_W'(DUTY_MAX);

  hds_state_t        state;
  logic [DUTY_W-1:0] ramp_duty;
  logic              ramp_top;
  logic              drive_ok;

  hds_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_flag     (por_flag),
    .regs_written (regs_written),
    .cal_done     (cal_done),
    .lock_ok      (lock_ok),
    .cal_gate     (cal_gate),
    .at_max       (ramp_top),
    .state        (state)
  );

  hds_ramp #(
    .DUTY_MAX       (DUTY_MAX),
    .LINES_PER_STEP (LINES_PER_STEP),
    .DUTY_W         (DUTY_W)
  ) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (state == HS_SOFT),
    .line_pulse (line_pulse),
    .duty       (ramp_duty),
    .at_max     (ramp_top)
  );

  always_comb begin
    drive_ok = 1'b0;
    duty_pct = '0;
    unique case (state)
      HS_SOFT: begin drive_ok = 1'b1; duty_pct = ramp_duty; end
      HS_RUN:  begin drive_ok = 1'b1; duty_pct = MAX_V; end
      HS_WAIT, HS_CAL: begin
        drive_ok = !cal_gate;
        duty_pct = cal_gate ? '0 : MAX_V;
      end
      default: begin drive_ok = 1'b0; duty_pct = '0; end
    endcase
  end

  assign hdrv_en = drive_ok && !por_flag && rst_n;
  assign cal_req = (state == HS_CAL);

  // R5: a finished calibration releases the request on the next cycle
  p_done_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && cal_done && !por_flag) |=> !cal_req);

  // R4: with gating on, no drive while calibration is requested
  p_gated_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && cal_gate) |-> !hdrv_en);
endmodule

// File: tb/sim_hdrv_startup_seq.sv
module sim_hdrv_startup_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_flag = 1'b0;
  logic       line_pulse = 1'b0;
  logic       regs_written = 1'b0;
  logic       cal_done = 1'b0;
  logic       lock_ok = 1'b1;
  logic       cal_gate = 1'b1;
  logic       cal_req;
  logic       hdrv_en;
  logic [6:0] duty_pct;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hdrv_startup_seq u0 (
    .clk(clk), .rst_n(rst_n), .por_flag(por_flag), .line_pulse(line_pulse),
    .regs_written(regs_written), .cal_done(cal_done), .lock_ok(lock_ok),
    .cal_gate(cal_gate), .cal_req(cal_req), .hdrv_en(hdrv_en), .duty_pct(duty_pct)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line();
    line_pulse = 1'b1; step(1);
    line_pulse = 1'b0; step(1);
  endtask

  task automatic pulse_regs();
    regs_written = 1'b1; step(1);
    regs_written = 1'b0;
  endtask

  task automatic pulse_done();
    cal_done = 1'b1; step(1);
    cal_done = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    chk("R1", hdrv_en, 0, "hdrv_en in reset");
    chk("R1", cal_req, 0, "cal_req in reset");
    chk("R1", duty_pct, 0, "duty in reset");
    rst_n = 1'b1; step(2);
    chk("R4", hdrv_en, 0, "drive while waiting");
    chk("R3", cal_req, 0, "req before download");
    for (int i = 0; i < 3; i++) pulse_line();
    chk("R11", duty_pct, 0, "duty after lines while waiting");
  endtask

  task automatic t_calib();
    pulse_regs();
    chk("R3", cal_req, 1, "req after download");
    chk("R4", hdrv_en, 0, "drive while calibrating");
    for (int i = 0; i < 3; i++) pulse_line();
    chk("R3", cal_req, 1, "req held");
    chk("R11", duty_pct, 0, "duty after lines while calibrating");
    pulse_done();
    chk("R5", cal_req, 0, "req after done");
    chk("R5", hdrv_en, 1, "drive at soft start");
    chk("R5", duty_pct, 0, "duty at soft start");
  endtask

  task automatic t_ramp();
    for (int i = 1; i <= 99; i++) begin
      pulse_line();
      if (i == 2) chk("R6", duty_pct, 1, "duty after 2 lines");
      if (i == 40) begin
        lock_ok = 1'b0; step(2);
        chk("R9", cal_req, 0, "req on unlock in soft start");
        chk("R9", hdrv_en, 1, "drive on unlock in soft start");
      end
      if (i == 41) chk("R9", duty_pct, 20, "ramp continues unlocked");
      if (i == 60) lock_ok = 1'b1;
    end
    chk("R6", duty_pct, 49, "duty after 99 lines");
    pulse_line();
    chk("R6", duty_pct, 50, "duty after 100 lines");
    for (int i = 0; i < 4; i++) pulse_line();
    chk("R7", duty_pct, 50, "duty holds");
    chk("R7", hdrv_en, 1, "drive holds");
  endtask

  task automatic t_relock();
    lock_ok = 1'b0; step(1);
    lock_ok = 1'b1;
    chk("R8", cal_req, 1, "req after lock loss");
    chk("R8", hdrv_en, 0, "drive after lock loss");
    chk("R8", duty_pct, 0, "duty after lock loss");
    pulse_done();
    chk("R5", duty_pct, 0, "soft start restarts");
    for (int i = 0; i < 4; i++) pulse_line();
  endtask

  task automatic t_por();
    por_flag = 1'b1; #1;
    chk("R2", hdrv_en, 0, "drive same cycle as por");
    step(1);
    chk("R2", cal_req, 0, "req under por");
    por_flag = 1'b0; step(3);
    chk("R2", cal_req, 0, "req after por before download");
    chk("R2", hdrv_en, 0, "drive after por before download");
    pulse_regs();
    chk("R2", cal_req, 1, "req after download following por");
  endtask

  task automatic t_skip();
    cal_gate = 1'b0; #1;
    chk("R10", hdrv_en, 1, "early drive while calibrating");
    chk("R10", duty_pct, 50, "early duty while calibrating");
    step(1);
    pulse_done();
    chk("R10", cal_req, 0, "req after done ungated");
    chk("R10", duty_pct, 50, "no ramp ungated");
    pulse_line(); pulse_line();
    chk("R10", duty_pct, 50, "duty stays at full");
    chk("R10", hdrv_en, 1, "drive stays on");
  endtask

  initial begin
    t_reset();
    t_calib();
    t_ramp();
    t_relock();
    t_por();
    t_skip();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule